// File: doc/BRIEF.md
# 64-bit Integer Divide and Remainder Unit

This block computes the quotient or the remainder of two integer operands for a 64-bit processor datapath. It covers signed and unsigned division on full 64-bit operands and on 32-bit word operands. The caller presents both operands, a 3-bit operation select and a word flag together with a one-cycle `start`. The unit answers with a one-cycle `done` and the result.

Inside, a radix-2 restoring loop works on the operand magnitudes, one quotient bit per cycle. The signs are applied once the loop has finished. Two cases never enter the loop: a zero divisor and signed overflow (most-negative value divided by minus one). Both finish in a single cycle. No trap is raised in either case; the architected values are returned instead.

Top module: `idiv_unit`

## Requirements
- R1: Unsigned operation (op_sel bit 0 = 1): the result is the truncated quotient, or the remainder, of the two operands taken as unsigned numbers.
- R2: Signed operation (op_sel bit 0 = 0): the quotient rounds toward zero and a nonzero remainder has the sign of the dividend.
- R3: With a zero divisor, the quotient is all ones and the remainder equals the dividend. In word mode, both values are sign-extended from bit 31.
- R4: Signed overflow returns the most-negative value as quotient and zero as remainder. In 64-bit mode the most-negative value is 0x8000000000000000. In word mode it is -2^31, sign-extended to 0xFFFFFFFF80000000.
- R5: In word mode (word_op = 1), only bits 31:0 of each operand are used. The 32-bit result is sign-extended to 64 bits in both the signed and the unsigned word forms.
- R6: Only op_sel bits 1:0 are decoded: bit 0 selects unsigned and bit 1 selects remainder. Bit 2 is ignored, so 100, 101, 110 and 111 give signed quotient, unsigned quotient, signed remainder and unsigned remainder, and 0xx behaves like 1xx.
- R7: `done` is high in the cycle after the `start` cycle for a zero divisor or signed overflow. Otherwise `done` is high 66 cycles after the `start` cycle in 64-bit mode and 34 cycles after it in word mode.
- R8: `done` is a one-cycle pulse, and `result` is valid in that cycle. `busy` is low whenever `done` is high. `busy` is high from the cycle after an accepted looping start until the result is delivered.
- R9: A `start` while `busy` is high is ignored. It produces no extra `done`, and the result in flight does not change.
- R10: After reset, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a new operation (taken only when not busy) |
| op_sel | input | 3 | Operation select: bit 0 unsigned, bit 1 remainder, bit 2 unused |
| word_op | input | 1 | Word mode: use the low 32 bits and sign-extend the result |
| op_a | input | 64 | Dividend |
| op_b | input | 64 | Divisor |
| busy | output | 1 | Iterative division in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | 64 | Quotient or remainder |

## Verification
Results are due after three fixed latencies, all counted from the cycle in which `start` is driven. The zero-divisor and overflow cases are due one cycle later. Word operations are due 34 cycles later, and full-width operations 66 cycles later. The driver records the cycle count when it raises `start` and pushes the expected value and expected latency into a scoreboard. The monitor samples on the falling edge, and each time `done` is high it compares both the value and the elapsed cycle count against the scoreboard. A `done` that arrives with an empty scoreboard is reported as a violation of the busy-start rule.

// File: rtl/idiv_pkg.sv
// Package: shared types and decode for the divide unit.
// Assumes op_sel follows the 3-bit minor opcode of the divide group:
// bit 0 = unsigned, bit 1 = remainder, bit 2 not decoded.
package idiv_pkg;

    localparam int XLEN_DEF = 64;

    typedef struct packed {
        logic is_word;
        logic is_unsigned;
        logic want_rem;
    } div_op_t;

    // Turns the raw select and the word flag into an operation record
    function automatic div_op_t decode_op(input logic [2:0] sel, input logic word);
        div_op_t o;
        o.is_word     = word;
        o.is_unsigned = sel[0];
        o.want_rem    = sel[1];
        return o;
    endfunction

endpackage

// File: rtl/idiv_prep.sv
// Module: operand conditioning.
// Narrows word operands, forms the magnitudes and result signs, detects a
// zero divisor and signed overflow, and builds the early-result value.
// Assumes XLEN is even. Word dividends are left-aligned so that the loop
// can run only XLEN/2 steps.
module idiv_prep #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]   op_a,
    input  logic [XLEN-1:0]   op_b,
    input  idiv_pkg::div_op_t op,
    output logic [XLEN-1:0]   dividend_mag,
    output logic [XLEN-1:0]   divisor_mag,
    output logic              neg_quo,
    output logic              neg_rem,
    output logic              by_zero,
    output logic              overflow,
    output logic [XLEN-1:0]   early_val
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] ext_a, ext_b, abs_a, abs_b, min_neg;
    logic            sgn_a, sgn_b;

    // Extend word operands by signedness, otherwise pass through
    always_comb begin
        if (op.is_word) begin
            ext_a = op.is_unsigned ? {{HALF{1'b0}}, op_a[HALF-1:0]}
                                   : {{HALF{op_a[HALF-1]}}, op_a[HALF-1:0]};
            ext_b = op.is_unsigned ? {{HALF{1'b0}}, op_b[HALF-1:0]}
                                   : {{HALF{op_b[HALF-1]}}, op_b[HALF-1:0]};
        end else begin
            ext_a = op_a;
            ext_b = op_b;
        end
    end

    // Signs, magnitudes and special-case detection
    always_comb begin
        sgn_a    = !op.is_unsigned && ext_a[XLEN-1];
        sgn_b    = !op.is_unsigned && ext_b[XLEN-1];
        abs_a    = sgn_a ? -ext_a : ext_a;
        abs_b    = sgn_b ? -ext_b : ext_b;
        min_neg  = op.is_word ? {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}}
                              : {1'b1, {(XLEN-1){1'b0}}};
        by_zero  = (ext_b == '0);
        overflow = !op.is_unsigned && (ext_a == min_neg) && (&ext_b);
        neg_quo  = sgn_a ^ sgn_b;
        neg_rem  = sgn_a;
        dividend_mag = op.is_word ? (abs_a << HALF) : abs_a;
        divisor_mag  = abs_b;
    end

    // Value returned without iterating
    always_comb begin
        if (by_zero) early_val = op.want_rem ? ext_a : '1;
        else         early_val = op.want_rem ? '0 : min_neg;
    end

endmodule

// File: rtl/idiv_core.sv
// Module: radix-2 restoring divide loop on unsigned magnitudes.
// On load it clears the partial remainder and captures both operands.
// Each step shifts one dividend bit into the remainder, tries a subtract
// and shifts the quotient bit in. Assumes the divisor is nonzero.
module idiv_core #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    logic [W:0]   rem_r;
    logic [W-1:0] quo_r, div_r;
    logic [W:0]   shifted;
    logic [W+1:0] trial;
    logic         fits;

    // Trial subtraction for one quotient bit
    always_comb begin
        shifted = {rem_r[W-1:0], quo_r[W-1]};
        trial   = {1'b0, shifted} - {2'b00, div_r};
        fits    = !trial[W+1];
    end

    // Loop registers: load, then one iteration per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_r <= '0;
            quo_r <= '0;
            div_r <= '0;
        end else if (load) begin
            rem_r <= '0;
            quo_r <= dividend;
            div_r <= divisor;
        end else if (step) begin
            rem_r <= fits ? trial[W:0] : shifted;
            quo_r <= {quo_r[W-2:0], fits};
        end
    end

    assign quo = quo_r;
    assign rem = rem_r[W-1:0];

    // R1
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(step) && !$past(load)) |-> (rem_r < {1'b0, div_r}));

endmodule

// File: rtl/idiv_unit.sv
// Module: top of the divide/remainder unit.
// Accepts an operation when idle. A zero divisor or signed overflow is
// answered on the next cycle. Any other operation runs XLEN (or XLEN/2)
// loop steps and then one sign-fixup cycle. start is ignored while busy.
module idiv_unit #(
    parameter int XLEN = idiv_pkg::XLEN_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op_sel,
    input  logic            word_op,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result
);
    import idiv_pkg::*;

    localparam int HALF = XLEN / 2;
    localparam int CW   = $clog2(XLEN);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} state_t;

    state_t          state;
    logic [CW-1:0]   cnt;
    div_op_t         op_in, op_q;
    logic            neg_quo_q, neg_rem_q, done_q;
    logic [XLEN-1:0] result_q;

    logic [XLEN-1:0] dmag, smag, early_val, quo, rem, fixed_val;
    logic            neg_quo, neg_rem, by_zero, overflow, special, accept;

    // Sign-extend from the word boundary when in word mode
    function automatic logic [XLEN-1:0] fit(input logic [XLEN-1:0] v, input logic w);
        return w ? {{HALF{v[HALF-1]}}, v[HALF-1:0]} : v;
    endfunction

    assign op_in   = decode_op(op_sel, word_op);
    assign accept  = start && (state == S_IDLE);
    assign special = by_zero || overflow;

    idiv_prep #(.XLEN(XLEN)) u_prep (
        .op_a(op_a), .op_b(op_b), .op(op_in),
        .dividend_mag(dmag), .divisor_mag(smag),
        .neg_quo(neg_quo), .neg_rem(neg_rem),
        .by_zero(by_zero), .overflow(overflow), .early_val(early_val)
    );

    idiv_core #(.W(XLEN)) u_core (
        .clk(clk), .rst_n(rst_n),
        .load(accept && !special), .step(state == S_RUN),
        .dividend(dmag), .divisor(smag),
        .quo(quo), .rem(rem)
    );

    // Apply the signs to the loop result and pick quotient or remainder
    always_comb begin
        if (op_q.want_rem) fixed_val = neg_rem_q ? -rem : rem;
        else               fixed_val = neg_quo_q ? -quo : quo;
    end

    // Sequencing: accept, iterate, fix up, deliver
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt       <= '0;
            op_q      <= '0;
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
            done_q    <= 1'b0;
            result_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: if (accept) begin
                    op_q      <= op_in;
                    neg_quo_q <= neg_quo;
                    neg_rem_q <= neg_rem;
                    if (special) begin
                        result_q <= fit(early_val, op_in.is_word);
                        done_q   <= 1'b1;
                    end else begin
                        state <= S_RUN;
                        cnt   <= op_in.is_word ? CW'(HALF - 1) : CW'(XLEN - 1);
                    end
                end
                S_RUN: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == '0) state <= S_FIX;
                end
                S_FIX: begin
                    result_q <= fit(fixed_val, op_q.is_word);
                    done_q   <= 1'b1;
                    state    <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy   = (state != S_IDLE);
    assign done   = done_q;
    assign result = result_q;

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    fast_special_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && special) |=> done);

    // R5
    word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q.is_word) |-> (result[XLEN-1:HALF] == {HALF{result[HALF-1]}}));

    // R9
    ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> ($stable(op_q) && $stable(neg_quo_q) && $stable(neg_rem_q)));

endmodule

// File: tb/test_idiv_unit.sv
// Scoreboard bench: the driver pushes the expected result and latency,
// and the monitor pops and compares them on each done pulse.
module test_idiv_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_sel = 3'b100;
    logic        word_op = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        busy, done;
    logic [63:0] result;

    always #5 clk = ~clk;

    idiv_unit i_idiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .word_op(word_op), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .result(result)
    );

    int cyc = 0;
    int errs = 0;
    int checks = 0;
    int t_start = 0;
    bit finished = 0;
    logic [63:0] exp_q[$];
    int          lat_q[$];
    string       tag_q[$];

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_res(input logic [63:0] a, input logic [63:0] b,
                                            input logic [2:0] f3, input logic w);
        logic [31:0] a32, b32, r32;
        logic [63:0] r64;
        a32 = a[31:0];
        b32 = b[31:0];
        if (w) begin
            if (b32 == 0) r32 = f3[1] ? a32 : 32'hFFFF_FFFF;
            else if (!f3[0] && a32 == 32'h8000_0000 && b32 == 32'hFFFF_FFFF)
                r32 = f3[1] ? 32'h0 : a32;
            else if (f3[0]) r32 = f3[1] ? (a32 % b32) : (a32 / b32);
            else if (f3[1]) r32 = $signed(a32) % $signed(b32);
            else r32 = $signed(a32) / $signed(b32);
            return {{32{r32[31]}}, r32};
        end
        if (b == 0) r64 = f3[1] ? a : '1;
        else if (!f3[0] && a == 64'h8000_0000_0000_0000 && b == '1)
            r64 = f3[1] ? 64'h0 : a;
        else if (f3[0]) r64 = f3[1] ? (a % b) : (a / b);
        else if (f3[1]) r64 = $signed(a) % $signed(b);
        else r64 = $signed(a) / $signed(b);
        return r64;
    endfunction

    function automatic int ref_lat(input logic [63:0] a, input logic [63:0] b,
                                   input logic [2:0] f3, input logic w);
        if (w) begin
            if (b[31:0] == 0) return 1;
            if (!f3[0] && a[31:0] == 32'h8000_0000 && b[31:0] == 32'hFFFF_FFFF) return 1;
            return 34;
        end
        if (b == 0) return 1;
        if (!f3[0] && a == 64'h8000_0000_0000_0000 && b == '1) return 1;
        return 66;
    endfunction

    // Drive one request, record expectations, wait for the result
    task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic [2:0] f3,
                         input logic w, input string tag);
        int lat;
        @(negedge clk);
        while (busy || exp_q.size() != 0) @(negedge clk);
        op_a = a; op_b = b; op_sel = f3; word_op = w; start = 1'b1;
        t_start = cyc;
        lat = ref_lat(a, b, f3, w);
        exp_q.push_back(ref_res(a, b, f3, w));
        lat_q.push_back(lat);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        if (lat > 1) chk(busy == 1'b1, "R8 busy", 64'(busy), 64'd1);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: compare every done pulse with the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected done", result, 64'h0);
            end else begin
                logic [63:0] e;
                int l;
                string t;
                e = exp_q.pop_front();
                l = lat_q.pop_front();
                t = tag_q.pop_front();
                chk(result == e, t, result, e);
                chk((cyc - t_start) == l, "R7 latency", 64'(cyc - t_start), 64'(l));
                chk(busy == 1'b0, "R8 busy at done", 64'(busy), 64'd0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] s;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(busy == 1'b0, "R10 busy", 64'(busy), 64'd0);
        chk(done == 1'b0, "R10 done", 64'(done), 64'd0);
        chk(result == 64'h0, "R10 result", result, 64'h0);
        rst_n = 1'b1;

        // R1 unsigned
        issue(64'd100, 64'd7, 3'b101, 1'b0, "R1 divu");
        issue(64'd100, 64'd7, 3'b111, 1'b0, "R1 remu");
        issue(64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 3'b101, 1'b0, "R1 divu max");
        // R2 signed rounding and remainder sign
        issue(-64'sd7, 64'd2, 3'b100, 1'b0, "R2 div neg");
        issue(-64'sd7, 64'd2, 3'b110, 1'b0, "R2 rem neg");
        issue(64'd7, -64'sd2, 3'b100, 1'b0, "R2 div negdiv");
        issue(64'd7, -64'sd2, 3'b110, 1'b0, "R2 rem negdiv");
        // R3 zero divisor
        issue(64'h1234, 64'h0, 3'b100, 1'b0, "R3 div zero");
        issue(64'h123, 64'h0, 3'b110, 1'b0, "R3 rem zero");
        issue(64'h55, 64'h0, 3'b101, 1'b0, "R3 divu zero");
        issue(64'hFFFF_FFFF_8000_0005 ^ 64'h0000_0001_0000_0000, 64'h7_0000_0000, 3'b111, 1'b1, "R3 remuw zero");
        // R4 signed overflow
        issue(64'h8000_0000_0000_0000, '1, 3'b100, 1'b0, "R4 div ovf");
        issue(64'h8000_0000_0000_0000, '1, 3'b110, 1'b0, "R4 rem ovf");
        issue(64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 3'b100, 1'b1, "R4 divw ovf");
        // R5 word forms
        issue(64'hAAAA_0000_FFFF_FFF0, 64'h5555_0000_0000_0010, 3'b101, 1'b1, "R5 divuw");
        issue(64'h0000_0001_8000_0001, 64'h1234_5678_FFFF_FFFF, 3'b111, 1'b1, "R5 remuw sext");
        issue(64'h1111_1111_FFFF_FF9C, 64'd7, 3'b100, 1'b1, "R5 divw neg");
        issue(64'h1111_1111_FFFF_FF9C, 64'd7, 3'b110, 1'b1, "R5 remw neg");
        // R6 bit 2 of op_sel ignored
        issue(64'd1000, 64'd9, 3'b001, 1'b0, "R6 sel 001 as divu");
        issue(-64'sd1000, 64'd9, 3'b010, 1'b0, "R6 sel 010 as rem");

        // R9 start while busy is ignored
        @(negedge clk);
        op_a = 64'd999_999; op_b = 64'd13; op_sel = 3'b100; word_op = 1'b0; start = 1'b1;
        t_start = cyc;
        exp_q.push_back(ref_res(64'd999_999, 64'd13, 3'b100, 1'b0));
        lat_q.push_back(66);
        tag_q.push_back("R9 in-flight result");
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        op_a = 64'd5; op_b = 64'd0; op_sel = 3'b111; word_op = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);

        // R1 R2 R5 mixed patterns
        s = 64'h0123_4567_89AB_CDEF;
        for (int i = 0; i < 24; i++) begin
            logic [63:0] a, b;
            logic [2:0]  f;
            s = s * 64'd6364136223846793005 + 64'd1442695040888963407;
            a = s;
            s = s * 64'd6364136223846793005 + 64'd1442695040888963407;
            b = (i % 3 == 0) ? (s >> 40) : s;
            f = 3'(4 + (i % 4));
            if (i >= 12) issue(a, b, f, 1'b1, "R5 mixed word");
            else if (f[0]) issue(a, b, f, 1'b0, "R1 mixed");
            else issue(a, b, f, 1'b0, "R2 mixed");
        end

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9 leftover", 64'(exp_q.size()), 64'd0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule